// File: doc/BRIEF.md
# Non-Page-Mode Asynchronous DRAM Controller

This block sits between a simple synchronous processor bus and a 32-bit asynchronous DRAM array of up to two blocks. Every bus request that falls inside one of the two blocks becomes one complete memory cycle. The controller asserts the row strobe of the selected block on a falling clock edge and switches the shared address pins from row to column. It then strobes the addressed byte lanes for a programmable width, captures read data or drives write data, and returns a one-cycle termination pulse on the bus. Nothing is held open between transfers, so each transfer pays for its full row, column and precharge time.

The strobes change on falling clock edges and the sequencing runs on rising edges. Software-visible timing comes in as static configuration inputs: the row-to-column delay, the column-strobe width, the precharge time, and an early-precharge option that releases the row strobe one clock ahead of the column strobe. The configuration must stay stable while a cycle is in progress. A request is held by the master until termination is seen, and is dropped or replaced during the termination cycle.

Top module: `dram_np_ctrl`

## Requirements
- R1: With `cfg_rcd`=0 the request is accepted on rising edge T0. On the falling edge that follows, only `ras_n[b]` goes low, where b is 0 for addresses with bits [31:26] equal to 0 and 1 for bits [31:26] equal to 1. Any other address produces no strobe and no termination.
- R2: `ma[i]` for i in 0..6 carries address bit 9+i in the row phase and bit 2+i in the column phase. `ma[7+j]` for j in 0..4 carries bit 17+2j in the row phase and bit 16+2j in the column phase.
- R3: The pins switch to the column address on the rising edge after RAS asserts when `cfg_rcd`=0, and one clock later when `cfg_rcd`=1.
- R4: CAS asserts on the falling edge after the column address appears and stays low for `cfg_cas`+1 clocks.
- R5: When `cfg_early`=1, RAS negates one clock before CAS. Otherwise RAS negates on the same falling edge as CAS.
- R6: Read data on `dq_in` is captured into `rdata` on the last rising edge at which CAS is low. `ack` is high for exactly the one clock that follows that edge.
- R7: `req_size` is encoded as 0 for a byte, 1 for a halfword and 2 for a word. Byte lane i covers `dq` bits 8i+7..8i, holds address offset i, and is strobed by `cas_n[i]`. Only the lanes that the size and `req_addr[1:0]` select go low.
- R8: On writes, `dwe_n` is low from the RAS falling edge until the CAS negation edge. `dq_oe` is high and `dq_out` carries `req_wdata` while CAS is low. On reads both stay inactive.
- R9: After a block's RAS negates, that block's RAS stays high for at least `cfg_pre`+1 clocks, and for exactly that long when a request is waiting and `cfg_early`=0. A request to the other block is not stalled.
- R10: While `rst_n` is low, all strobes are negated, `dq_oe` is low and `ack` is low.
- R11: At most one RAS line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present, held until `ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, lane-aligned |
| ack | output | 1 | One-cycle termination |
| rdata | output | 32 | Captured read data |
| cfg_rcd | input | 1 | Extra row-to-column clock |
| cfg_cas | input | 2 | CAS width minus one, in clocks |
| cfg_pre | input | 2 | Precharge clocks minus one |
| cfg_early | input | 1 | Negate RAS one clock before CAS |
| ras_n | output | 2 | Row strobes, one per block |
| cas_n | output | 4 | Column strobes, one per byte lane |
| dwe_n | output | 1 | DRAM write enable |
| ma | output | 12 | Multiplexed row/column address |
| dq_out | output | 32 | Write data to DRAM |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | 32 | Read data from DRAM |

## Verification
The precharge hold-off of one block and the acceptance of a new request for the other block can fall on the same rising edge. This happens because only the block that just closed is fenced. The bench provokes it by presenting a request to the second block in the termination cycle of a transfer to the first block while the precharge count is nonzero. A re-request to the same block provides the contrast. The falling edges up to the next row strobe are counted in both cases: one edge for the other block, and the precharge count plus one for the same block.

// File: rtl/dnp_pkg.sv
// Shared types and helpers for the non-page-mode DRAM controller.
// Assumes a 32-bit data path split into four byte lanes.
package dnp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_RCD  = 2'd2,
        ST_COL  = 2'd3
    } dnp_state_e;

    localparam int NBLK  = 2;
    localparam int NLANE = 4;

    // Lanes strobed for a transfer of the given size at the given offset.
    function automatic logic [NLANE-1:0] lane_sel(input logic [1:0] size,
                                                  input logic [1:0] lo);
        case (size)
            2'd0:    lane_sel = 4'b0001 << lo;
            2'd1:    lane_sel = lo[1] ? 4'b1100 : 4'b0011;
            default: lane_sel = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/dnp_hit_decode.sv
// Block hit decoder: compares the upper address bits with each block's base.
// Assumes block bases are aligned to the block size 2**AW.
module dnp_hit_decode #(
    parameter int          AW    = 26,
    parameter logic [31:0] BASE0 = 32'h0000_0000,
    parameter logic [31:0] BASE1 = 32'h0400_0000
) (
    input  logic [31:AW] addr_hi,
    output logic [1:0]   hit
);
    // One comparator per block.
    for (genvar b = 0; b < dnp_pkg::NBLK; b++) begin : g_blk
        localparam logic [31:0] BASE = (b == 0) ? BASE0 : BASE1;
        assign hit[b] = (addr_hi == BASE[31:AW]);
    end
endmodule

// File: rtl/dnp_addr_mux.sv
// Row/column address multiplexer with interleaved upper pins.
// Low seven pins take a contiguous field; each extra size step adds one
// pin that takes an odd bit for the row and the even bit below it for the column.
module dnp_addr_mux #(
    parameter int SIZE_STEP = 5,
    localparam int MA_W     = 7 + SIZE_STEP,
    localparam int AW       = 16 + 2 * SIZE_STEP
) (
    input  logic [AW-1:2]   addr,
    input  logic            col_sel,
    output logic [MA_W-1:0] ma
);
    // Contiguous low pins.
    for (genvar i = 0; i < 7; i++) begin : g_low
        assign ma[i] = col_sel ? addr[2 + i] : addr[9 + i];
    end
    // Interleaved upper pins, one per size step.
    for (genvar j = 0; j < SIZE_STEP; j++) begin : g_high
        assign ma[7 + j] = col_sel ? addr[16 + 2 * j] : addr[17 + 2 * j];
    end
endmodule

// File: rtl/dnp_sequencer.sv
// Rising-edge sequencer: accepts a request, steps row/delay/column phases,
// captures read data, issues termination and runs per-block precharge counters.
// Assumes configuration inputs are stable while a cycle is in progress.
module dnp_sequencer
    import dnp_pkg::*;
#(
    parameter int AW    = 26,
    parameter int CAS_W = 2,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    input  logic [31:0]      req_wdata,
    input  logic [1:0]       hit,
    input  logic             cfg_rcd,
    input  logic [CAS_W-1:0] cfg_cas,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic [31:0]      dq_in,
    output dnp_state_e       state,
    output logic             last,
    output logic             blk,
    output logic             wr,
    output logic [3:0]       lanes,
    output logic [AW-1:2]    lat_addr,
    output logic [31:0]      wdata,
    output logic             ack,
    output logic [31:0]      rdata
);
    logic [CAS_W-1:0] cnt;
    logic [PRE_W-1:0] pre_cnt [NBLK];
    logic [NBLK-1:0]  pre_idle;
    logic             pick;
    logic             take;

    assign pick = hit[1];
    for (genvar b = 0; b < NBLK; b++) begin : g_idle
        assign pre_idle[b] = (pre_cnt[b] == '0);
    end
    assign take = (state == ST_IDLE) && req_valid && (|hit) && pre_idle[pick];
    assign last = (state == ST_COL) && (cnt == cfg_cas);

    // Phase sequencing, request latching, read capture and termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            blk      <= 1'b0;
            wr       <= 1'b0;
            lanes    <= '0;
            lat_addr <= '0;
            wdata    <= '0;
            ack      <= 1'b0;
            rdata    <= '0;
        end else begin
            ack <= last;
            case (state)
                ST_IDLE: if (take) begin
                    state    <= ST_ROW;
                    blk      <= pick;
                    wr       <= req_write;
                    lanes    <= lane_sel(req_size, req_addr[1:0]);
                    lat_addr <= req_addr[AW-1:2];
                    wdata    <= req_wdata;
                    cnt      <= '0;
                end
                ST_ROW:  state <= cfg_rcd ? ST_RCD : ST_COL;
                ST_RCD:  state <= ST_COL;
                default: begin
                    if (last) begin
                        state <= ST_IDLE;
                        if (!wr) rdata <= dq_in;
                    end else begin
                        cnt <= cnt + CAS_W'(1);
                    end
                end
            endcase
        end
    end

    // Precharge hold-off per block, loaded when that block's cycle ends.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBLK; b++) begin
            if (!rst_n)
                pre_cnt[b] <= '0;
            else if (last && (blk == 1'(b)))
                pre_cnt[b] <= cfg_pre;
            else if (!pre_idle[b])
                pre_cnt[b] <= pre_cnt[b] - PRE_W'(1);
        end
    end
endmodule

// File: rtl/dnp_strobe_gen.sv
// Falling-edge strobe registers: RAS per block, CAS per lane, write enable
// and data drive enable, all derived from the sequencer phase.
// Assumes the sequencer state changes only on rising edges.
module dnp_strobe_gen
    import dnp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dnp_state_e state,
    input  logic       last,
    input  logic       blk,
    input  logic       wr,
    input  logic [3:0] lanes,
    input  logic       cfg_early,
    output logic [1:0] ras_n,
    output logic [3:0] cas_n,
    output logic       dwe_n,
    output logic       dq_oe
);
    logic active;
    logic ras_on;

    assign active = (state != ST_IDLE);
    assign ras_on = active && !(cfg_early && last);

    // Strobes move half a clock after the phase that calls for them.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ras_n <= 2'b11;
            cas_n <= 4'hF;
            dwe_n <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ras_n <= ~({2{ras_on}} & (blk ? 2'b10 : 2'b01));
            cas_n <= (state == ST_COL) ? ~lanes : 4'hF;
            dwe_n <= !(active && wr);
            dq_oe <= (state == ST_COL) && wr;
        end
    end
endmodule

// File: rtl/dram_np_ctrl.sv
// Top of the non-page-mode asynchronous DRAM controller: hit decode,
// rising-edge sequencer, falling-edge strobes and row/column address mux.
// Assumes the master holds a request until ack and config is static per cycle.
module dram_np_ctrl #(
    parameter int          SIZE_STEP = 5,
    parameter int          CAS_W     = 2,
    parameter int          PRE_W     = 2,
    parameter logic [31:0] BASE0     = 32'h0000_0000,
    parameter logic [31:0] BASE1     = 32'h0400_0000,
    localparam int         MA_W      = 7 + SIZE_STEP,
    localparam int         AW        = 16 + 2 * SIZE_STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [31:0]      req_addr,
    input  logic [31:0]      req_wdata,
    output logic             ack,
    output logic [31:0]      rdata,
    input  logic             cfg_rcd,
    input  logic [CAS_W-1:0] cfg_cas,
    input  logic [PRE_W-1:0] cfg_pre,
    input  logic             cfg_early,
    output logic [1:0]       ras_n,
    output logic [3:0]       cas_n,
    output logic             dwe_n,
    output logic [MA_W-1:0]  ma,
    output logic [31:0]      dq_out,
    output logic             dq_oe,
    input  logic [31:0]      dq_in
);
    import dnp_pkg::*;

    logic [1:0]    hit;
    dnp_state_e    state;
    logic          last;
    logic          blk;
    logic          wr;
    logic [3:0]    lanes;
    logic [AW-1:2] lat_addr;
    logic [31:0]   wdata;

    dnp_hit_decode #(.AW(AW), .BASE0(BASE0), .BASE1(BASE1)) hit_i (
        .addr_hi (req_addr[31:AW]),
        .hit     (hit)
    );

    dnp_sequencer #(.AW(AW), .CAS_W(CAS_W), .PRE_W(PRE_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr[AW-1:0]),
        .req_wdata (req_wdata),
        .hit       (hit),
        .cfg_rcd   (cfg_rcd),
        .cfg_cas   (cfg_cas),
        .cfg_pre   (cfg_pre),
        .dq_in     (dq_in),
        .state     (state),
        .last      (last),
        .blk       (blk),
        .wr        (wr),
        .lanes     (lanes),
        .lat_addr  (lat_addr),
        .wdata     (wdata),
        .ack       (ack),
        .rdata     (rdata)
    );

    dnp_strobe_gen strb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .last      (last),
        .blk       (blk),
        .wr        (wr),
        .lanes     (lanes),
        .cfg_early (cfg_early),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .dwe_n     (dwe_n),
        .dq_oe     (dq_oe)
    );

    dnp_addr_mux #(.SIZE_STEP(SIZE_STEP)) mux_i (
        .addr    (lat_addr),
        .col_sel (state == ST_COL),
        .ma      (ma)
    );

    assign dq_out = wdata;
endmodule

// File: rtl/dnp_ctrl_checker.sv
// Protocol checker for the DRAM controller pins, attached by bind.
// Assumes it samples on rising edges, where the falling-edge strobes are settled.
module dnp_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ras_n,
    input logic [3:0] cas_n,
    input logic       dwe_n,
    input logic       dq_oe,
    input logic       ack,
    input logic       cfg_early
);
    // R11: never two blocks open at once.
    a_r11_one_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ras_n));

    // R6: termination is a single-clock pulse.
    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R6: termination follows a clock in which a column strobe was low.
    a_r6_ack_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ($past(cas_n) != 4'hF));

    // R8: data is driven only inside a write with a column strobe low.
    a_r8_data_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!dwe_n && (cas_n != 4'hF)));

    // R5: without early precharge a column strobe is always under an open row.
    a_r5_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ((cas_n != 4'hF) && !cfg_early) |-> (ras_n != 2'b11));
endmodule

bind dram_np_ctrl dnp_ctrl_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .dwe_n     (dwe_n),
    .dq_oe     (dq_oe),
    .ack       (ack),
    .cfg_early (cfg_early)
);

// File: tb/dram_np_ctrl_tb_top.sv
// Self-checking bench: a vector table of single transfers, then directed
// tests for reset, address miss and precharge stalls on one or both blocks.
module dram_np_ctrl_tb_top;

    typedef struct packed {
        logic        wr;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  cas;
        logic        rcd;
        logic        early;
        logic [3:0]  lanes;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd2, 32'h0012_3458, 32'h0,           2'd1, 1'b0, 1'b0, 4'b1111},
        '{1'b1, 2'd0, 32'h0155_AA01, 32'h0000_5A00,   2'd0, 1'b0, 1'b1, 4'b0010},
        '{1'b1, 2'd1, 32'h0400_0C02, 32'hBEEF_0000,   2'd2, 1'b1, 1'b0, 4'b1100},
        '{1'b0, 2'd0, 32'h0731_0003, 32'h0,           2'd3, 1'b1, 1'b1, 4'b1000},
        '{1'b1, 2'd2, 32'h03FF_FFFC, 32'h1234_5678,   2'd1, 1'b0, 1'b1, 4'b1111},
        '{1'b0, 2'd1, 32'h0200_0000, 32'h0,           2'd0, 1'b1, 1'b0, 4'b0011},
        '{1'b1, 2'd0, 32'h0000_0002, 32'h00C3_0000,   2'd2, 1'b0, 1'b0, 4'b0100},
        '{1'b0, 2'd2, 32'h07FF_FFF0, 32'h0,           2'd0, 1'b0, 1'b1, 4'b1111}
    };

    localparam int ROWB [12] = '{9, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25};
    localparam int COLB [12] = '{2, 3, 4, 5, 6, 7, 8, 16, 18, 20, 22, 24};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ack;
    logic [31:0] rdata;
    logic        cfg_rcd = 1'b0;
    logic [1:0]  cfg_cas = 2'd0;
    logic [1:0]  cfg_pre = 2'd0;
    logic        cfg_early = 1'b0;
    logic [1:0]  ras_n;
    logic [3:0]  cas_n;
    logic        dwe_n;
    logic [11:0] ma;
    logic [31:0] dq_out;
    logic        dq_oe;
    logic [31:0] dq_in = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dram_np_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ack       (ack),
        .rdata     (rdata),
        .cfg_rcd   (cfg_rcd),
        .cfg_cas   (cfg_cas),
        .cfg_pre   (cfg_pre),
        .cfg_early (cfg_early),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .dwe_n     (dwe_n),
        .ma        (ma),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .dq_in     (dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] row_of(input logic [31:0] a);
        logic [11:0] r;
        for (int i = 0; i < 12; i++) r[i] = a[ROWB[i]];
        return r;
    endfunction

    function automatic logic [11:0] col_of(input logic [31:0] a);
        logic [11:0] c;
        for (int i = 0; i < 12; i++) c[i] = a[COLB[i]];
        return c;
    endfunction

    // One transfer from request to the falling edge after termination.
    task automatic run_txn(input vec_t v, input logic [31:0] pat);
        logic [1:0] exp_ras;
        int         n;
        exp_ras   = v.addr[26] ? 2'b01 : 2'b10;
        n         = int'(v.cas) + 1;
        cfg_cas   = v.cas;
        cfg_rcd   = v.rcd;
        cfg_early = v.early;
        req_write = v.wr;
        req_size  = v.size;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        dq_in     = pat;
        req_valid = 1'b1;
        @(posedge clk); #2;
        chk("R1 ras idle at accept edge", {30'd0, ras_n}, 32'h3);
        chk("R2 row address", {20'd0, ma}, {20'd0, row_of(v.addr)});
        chk("R6 no early ack", {31'd0, ack}, 32'd0);
        @(negedge clk); #2;
        chk("R1 ras of hit block", {30'd0, ras_n}, {30'd0, exp_ras});
        chk("R8 write enable with ras", {31'd0, dwe_n}, {31'd0, !v.wr});
        if (v.rcd) begin
            @(posedge clk); #2;
            chk("R3 row held during delay", {20'd0, ma}, {20'd0, row_of(v.addr)});
        end
        @(posedge clk); #2;
        chk("R3 column address", {20'd0, ma}, {20'd0, col_of(v.addr)});
        chk("R4 cas not before falling edge", {28'd0, cas_n}, 32'hF);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #2;
            chk("R7 r4_ lanes strobed", {28'd0, cas_n}, {28'd0, ~v.lanes});
            if (v.wr) begin
                chk("R8 data driven", {31'd0, dq_oe}, 32'd1);
                chk("R8 write data", dq_out, v.wdata);
            end else begin
                chk("R8 no drive on read", {31'd0, dq_oe}, 32'd0);
            end
            if (k == n - 1)
                chk("R5 ras at last cas clock", {30'd0, ras_n},
                    v.early ? 32'h3 : {30'd0, exp_ras});
        end
        @(posedge clk); #2;
        chk("R6 ack", {31'd0, ack}, 32'd1);
        if (!v.wr) chk("R6 read data", rdata, pat);
        @(negedge clk); #2;
        chk("R4 cas negated", {28'd0, cas_n}, 32'hF);
        chk("R5 ras negated", {30'd0, ras_n}, 32'h3);
        chk("R8 write enable released", {31'd0, dwe_n}, 32'd1);
        req_valid = 1'b0;
    endtask

    // Count falling edges until the given block's RAS goes low.
    task automatic count_to_ras(input int b, output int k);
        k = 0;
        while (ras_n[b] && k < 12) begin
            @(negedge clk); #2;
            k++;
        end
    endtask

    task automatic finish_req;
        while (!ack) begin
            @(posedge clk); #2;
        end
        @(negedge clk); #2;
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        int   k;
        int   act;
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk("R10 ras reset", {30'd0, ras_n}, 32'h3);
        chk("R10 cas reset", {28'd0, cas_n}, 32'hF);
        chk("R10 dwe reset", {31'd0, dwe_n}, 32'd1);
        chk("R10 ack reset", {31'd0, ack}, 32'd0);
        chk("R10 oe reset", {31'd0, dq_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;

        // Table of single transfers
        for (int i = 0; i < NVEC; i++) begin
            run_txn(VECS[i], 32'hC0DE_0000 | i);
            repeat (2) @(negedge clk);
            #2;
        end

        // R1: address outside both blocks is ignored
        req_addr  = 32'h0800_0000;
        req_write = 1'b1;
        req_valid = 1'b1;
        act = 0;
        repeat (8) begin
            @(negedge clk); #2;
            if (ras_n != 2'b11 || cas_n != 4'hF || ack || !dwe_n) act++;
        end
        req_valid = 1'b0;
        chk("R1 miss causes no activity", act, 0);

        // R9: back-to-back on the same block waits out precharge
        cfg_pre = 2'd2;
        v = '{1'b0, 2'd2, 32'h0000_0100, 32'h0, 2'd0, 1'b0, 1'b0, 4'b1111};
        run_txn(v, 32'h1111_2222);
        req_addr  = 32'h0000_0200;
        req_valid = 1'b1;
        count_to_ras(0, k);
        chk("R9 same block stalled", k, 3);
        finish_req();

        // R9: the other block proceeds while the first one precharges
        run_txn(v, 32'h3333_4444);
        req_addr  = 32'h0400_0200;
        req_valid = 1'b1;
        count_to_ras(1, k);
        chk("R9 other block not stalled", k, 1);
        finish_req();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule